// File: doc/BRIEF.md
# Host-DSP Doorbell Mailbox

This block carries soft interrupts in both directions between a host processor bus and an embedded DSP bus. Each side has its own synchronous register port with its own address map. A sender writes an 8-bit vector into its outgoing register. That write sets a pending bit on the receiving side, which raises the receiver's interrupt line when the receiver has enabled it. The same write also sets a busy flag that the sender can read.

The receiver reads the vector, and that read clears the pending bit. The busy flag stays set until the receiver writes a zero to it, which tells the sender that a new doorbell may be rung. A shared 16-bit parameter word can be read and written from both ports, so extra arguments can travel with an interrupt.

Reads are combinational: read data is valid while the read strobe is high, and it is zero when no read is issued. All side effects of a read or a write take place at the rising clock edge that ends the access.

Top module: `hdmbx_top`

## Requirements
- R1: A host write to host address 0x50 stores the write data as the host-to-DSP vector and, from the next cycle, sets both the host-to-DSP pending bit and the host-to-DSP busy flag.
- R2: A DSP read of DSP address 0x3050 returns the host-to-DSP vector and clears the host-to-DSP pending bit. It leaves the busy flag unchanged. A host read of 0x50 returns the busy flag in bit 0, with zeros above.
- R3: A DSP write to 0x3050 with data bit 0 equal to 0 clears the host-to-DSP busy flag. A write there with bit 0 equal to 1 has no effect.
- R4: A DSP write to 0x3058 stores the DSP-to-host vector and sets the DSP-to-host pending bit and busy flag. A host read of 0x58 returns that vector and clears the pending bit. A DSP read of 0x3058 returns the busy flag in bit 0.
- R5: A host write to 0x58 with data bit 0 equal to 0 clears the DSP-to-host busy flag. A write there with bit 0 equal to 1 has no effect.
- R6: Each interrupt line is high exactly when its pending bit and the receiver's enable bit are both 1. The host enable is bit 0 at host 0x76 and drives the host line. The DSP enable is bit 0 at DSP 0x3076 and drives the DSP line. Pending bits can be read in bit 0 at host 0x75 and DSP 0x3074, and reading them does not clear them.
- R7: The 16-bit parameter word is written and read bytewise: host 0x60 and DSP 0x3060 hold bits 7:0, host 0x61 and DSP 0x3061 hold bits 15:8. Both ports always see the same value.
- R8: When both ports write the same parameter byte in one cycle, the DSP data is kept.
- R9: When a pending bit or busy flag is set and cleared in the same cycle, it ends up set.
- R10: After reset, every register is 0, both interrupt lines are low and both enables are off.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| h_addr | input | 8 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, combinational, 0 when h_rd is low |
| h_irq | output | 1 | Interrupt toward the host |
| d_addr | input | 16 | DSP register address |
| d_wr | input | 1 | DSP write strobe |
| d_rd | input | 1 | DSP read strobe |
| d_wdata | input | 8 | DSP write data |
| d_rdata | output | 8 | DSP read data, combinational, 0 when d_rd is low |
| d_irq | output | 1 | Interrupt toward the DSP |

## Verification
Directed sequences ring each doorbell in turn and show that three effects are kept apart: the vector read clears only pending, a status read clears nothing, and only a zero in bit 0 releases busy. Collision patterns exercise the two priority rules, which a serial access pattern would never reach: set against clear on the same bit, and both ports writing the same parameter byte. Long random traffic then mixes reads, writes, enables and unmapped addresses on both ports at once, so that a coupling between the two directions or a wrong address decode shows up as a read-data or interrupt mismatch.

// File: rtl/hdmbx_pkg.sv
// Package: shared widths and the two register address maps of the mailbox.
// Assumes 8-bit data on both ports; the parameter word is two byte lanes.
package hdmbx_pkg;
    localparam int DATA_W   = 8;
    localparam int HADDR_W  = 8;
    localparam int DADDR_W  = 16;
    localparam int CTL_LANES = 2;
    localparam int CTL_W    = CTL_LANES * DATA_W;

    // host map
    localparam logic [HADDR_W-1:0] H_SEND_A = 8'h50;
    localparam logic [HADDR_W-1:0] H_RECV_A = 8'h58;
    localparam logic [HADDR_W-1:0] H_STAT_A = 8'h75;
    localparam logic [HADDR_W-1:0] H_EN_A   = 8'h76;
    localparam logic [HADDR_W-1:0] H_CLO_A  = 8'h60;
    localparam logic [HADDR_W-1:0] H_CHI_A  = 8'h61;

    // DSP map
    localparam logic [DADDR_W-1:0] D_SEND_A = 16'h3058;
    localparam logic [DADDR_W-1:0] D_RECV_A = 16'h3050;
    localparam logic [DADDR_W-1:0] D_STAT_A = 16'h3074;
    localparam logic [DADDR_W-1:0] D_EN_A   = 16'h3076;
    localparam logic [DADDR_W-1:0] D_CLO_A  = 16'h3060;
    localparam logic [DADDR_W-1:0] D_CHI_A  = 16'h3061;
endpackage

// File: rtl/hdmbx_port.sv
// Module: address decoder and read multiplexer for one side of the mailbox.
// Purely combinational. It turns bus strobes into per-register events and
// returns read data while rd is high (zero otherwise or when unmapped).
// Assumes rd and wr are single-cycle, level strobes sampled at the clock edge.
module hdmbx_port #(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int LANES = 2,
    parameter logic [AW-1:0] SEND_A = '0,
    parameter logic [AW-1:0] RECV_A = '0,
    parameter logic [AW-1:0] STAT_A = '0,
    parameter logic [AW-1:0] EN_A   = '0,
    parameter logic [AW-1:0] CLO_A  = '0,
    parameter logic [AW-1:0] CHI_A  = '0
) (
    input  logic [AW-1:0]       addr,
    input  logic                wr,
    input  logic                rd,
    input  logic                wbit0,
    input  logic                send_busy,
    input  logic [DW-1:0]       recv_vec,
    input  logic                recv_pend,
    input  logic                recv_en,
    input  logic [LANES*DW-1:0] ctl,
    output logic                send_we,
    output logic                recv_rd,
    output logic                recv_clr,
    output logic                en_we,
    output logic [LANES-1:0]    ctl_we,
    output logic [DW-1:0]       rdata
);
    localparam int PAD = DW - 1;

    // write-side event decode
    always_comb begin
        send_we  = wr && (addr == SEND_A);
        recv_clr = wr && (addr == RECV_A) && !wbit0;
        en_we    = wr && (addr == EN_A);
        ctl_we   = {wr && (addr == CHI_A), wr && (addr == CLO_A)};
        recv_rd  = rd && (addr == RECV_A);
    end

    // read multiplexer
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                SEND_A:  rdata = {{PAD{1'b0}}, send_busy};
                RECV_A:  rdata = recv_vec;
                STAT_A:  rdata = {{PAD{1'b0}}, recv_pend};
                EN_A:    rdata = {{PAD{1'b0}}, recv_en};
                CLO_A:   rdata = ctl[DW-1:0];
                CHI_A:   rdata = ctl[LANES*DW-1:DW];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hdmbx_dir.sv
// Module: one doorbell direction (vector, pending, busy, enable, irq).
// The sender rings it and the receiver acknowledges and releases it. When
// a set and a clear of the same bit arrive together, the set wins.
module hdmbx_dir #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ring,
    input  logic [DW-1:0] ring_d,
    input  logic          ack,
    input  logic          release_busy,
    input  logic          en_we,
    input  logic          en_d,
    output logic [DW-1:0] vec,
    output logic          pend,
    output logic          busy,
    output logic          en,
    output logic          irq
);
    // vector register, loaded by the sender
    always_ff @(posedge clk) begin
        if (!rst_n)    vec <= '0;
        else if (ring) vec <= ring_d;
    end

    // pending bit: set by ring, cleared by the receiver's vector read
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (ring) pend <= 1'b1;
        else if (ack)  pend <= 1'b0;
    end

    // busy flag: set by ring, cleared only by an explicit write of zero
    always_ff @(posedge clk) begin
        if (!rst_n)            busy <= 1'b0;
        else if (ring)         busy <= 1'b1;
        else if (release_busy) busy <= 1'b0;
    end

    // receiver's interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= 1'b0;
        else if (en_we) en <= en_d;
    end

    // interrupt line toward the receiver
    always_comb irq = pend && en;
endmodule

// File: rtl/hdmbx_ctl.sv
// Module: shared parameter word, one byte lane per generate step.
// Both ports write bytewise; on a same-lane collision the DSP data wins.
module hdmbx_ctl #(
    parameter int DW = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    h_we,
    input  logic [DW-1:0]       h_d,
    input  logic [LANES-1:0]    d_we,
    input  logic [DW-1:0]       d_d,
    output logic [LANES*DW-1:0] word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // one byte lane with DSP-first priority
        always_ff @(posedge clk) begin
            if (!rst_n)       word[i*DW +: DW] <= '0;
            else if (d_we[i]) word[i*DW +: DW] <= d_d;
            else if (h_we[i]) word[i*DW +: DW] <= h_d;
        end
    end
endmodule

// File: rtl/hdmbx_top.sv
// Module: bidirectional host-DSP doorbell mailbox.
// It joins two port decoders, two doorbell directions and the shared
// parameter word. Assumes one clock for both buses and synchronous reset.
module hdmbx_top
    import hdmbx_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int HAW = HADDR_W,
    parameter int DAW = DADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HAW-1:0] h_addr,
    input  logic           h_wr,
    input  logic           h_rd,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    output logic           h_irq,
    input  logic [DAW-1:0] d_addr,
    input  logic           d_wr,
    input  logic           d_rd,
    input  logic [DW-1:0]  d_wdata,
    output logic [DW-1:0]  d_rdata,
    output logic           d_irq
);
    localparam int CW = CTL_LANES * DW;

    logic [DW-1:0]        h2d_vec, d2h_vec;
    logic                 h2d_pend, h2d_busy, h2d_en;
    logic                 d2h_pend, d2h_busy, d2h_en;
    logic                 h_send, h_ack, h_clr, h_en_we;
    logic                 d_send, d_ack, d_clr, d_en_we;
    logic [CTL_LANES-1:0] h_ctl_we, d_ctl_we;
    logic [CW-1:0]        ctl_word;

    hdmbx_port #(
        .AW(HAW), .DW(DW), .LANES(CTL_LANES),
        .SEND_A(H_SEND_A), .RECV_A(H_RECV_A), .STAT_A(H_STAT_A),
        .EN_A(H_EN_A), .CLO_A(H_CLO_A), .CHI_A(H_CHI_A)
    ) u_hport (
        .addr(h_addr), .wr(h_wr), .rd(h_rd), .wbit0(h_wdata[0]),
        .send_busy(h2d_busy), .recv_vec(d2h_vec), .recv_pend(d2h_pend),
        .recv_en(d2h_en), .ctl(ctl_word),
        .send_we(h_send), .recv_rd(h_ack), .recv_clr(h_clr),
        .en_we(h_en_we), .ctl_we(h_ctl_we), .rdata(h_rdata)
    );

    hdmbx_port #(
        .AW(DAW), .DW(DW), .LANES(CTL_LANES),
        .SEND_A(D_SEND_A), .RECV_A(D_RECV_A), .STAT_A(D_STAT_A),
        .EN_A(D_EN_A), .CLO_A(D_CLO_A), .CHI_A(D_CHI_A)
    ) u_dport (
        .addr(d_addr), .wr(d_wr), .rd(d_rd), .wbit0(d_wdata[0]),
        .send_busy(d2h_busy), .recv_vec(h2d_vec), .recv_pend(h2d_pend),
        .recv_en(h2d_en), .ctl(ctl_word),
        .send_we(d_send), .recv_rd(d_ack), .recv_clr(d_clr),
        .en_we(d_en_we), .ctl_we(d_ctl_we), .rdata(d_rdata)
    );

    hdmbx_dir #(.DW(DW)) u_h2d (
        .clk(clk), .rst_n(rst_n),
        .ring(h_send), .ring_d(h_wdata), .ack(d_ack), .release_busy(d_clr),
        .en_we(d_en_we), .en_d(d_wdata[0]),
        .vec(h2d_vec), .pend(h2d_pend), .busy(h2d_busy), .en(h2d_en),
        .irq(d_irq)
    );

    hdmbx_dir #(.DW(DW)) u_d2h (
        .clk(clk), .rst_n(rst_n),
        .ring(d_send), .ring_d(d_wdata), .ack(h_ack), .release_busy(h_clr),
        .en_we(h_en_we), .en_d(h_wdata[0]),
        .vec(d2h_vec), .pend(d2h_pend), .busy(d2h_busy), .en(d2h_en),
        .irq(h_irq)
    );

    hdmbx_ctl #(.DW(DW), .LANES(CTL_LANES)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_ctl_we), .h_d(h_wdata), .d_we(d_ctl_we), .d_d(d_wdata),
        .word(ctl_word)
    );
endmodule

// File: rtl/hdmbx_chk.sv
// Checker: temporal properties of the mailbox, bound into hdmbx_top.
module hdmbx_chk
    import hdmbx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [HADDR_W-1:0] h_addr,
    input logic               h_wr,
    input logic               h_rd,
    input logic [DATA_W-1:0]  h_wdata,
    input logic [DADDR_W-1:0] d_addr,
    input logic               d_wr,
    input logic               d_rd,
    input logic [DATA_W-1:0]  d_wdata,
    input logic               h2d_pend,
    input logic               h2d_busy,
    input logic               d2h_pend,
    input logic               d2h_busy,
    input logic [CTL_W-1:0]   ctl_word
);
    AST_H2D_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == H_SEND_A) |=> (h2d_pend && h2d_busy)); // R1
    AST_D2H_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && d_addr == D_SEND_A) |=> (d2h_pend && d2h_busy)); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_rd && d_addr == D_RECV_A && !(h_wr && h_addr == H_SEND_A)) |=> !h2d_pend); // R2
    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (h2d_busy && !(d_wr && d_addr == D_RECV_A && !d_wdata[0])) |=> h2d_busy); // R3
    AST_HBUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (d2h_busy && !(h_wr && h_addr == H_RECV_A && !h_wdata[0])) |=> d2h_busy); // R5
    AST_DSP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && d_addr == D_CLO_A && h_wr && h_addr == H_CLO_A)
        |=> ctl_word[DATA_W-1:0] == $past(d_wdata)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wr && d_addr == D_SEND_A && h_rd && h_addr == H_RECV_A) |=> d2h_pend); // R9
endmodule

bind hdmbx_top hdmbx_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
    .d_addr(d_addr), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata),
    .h2d_pend(h2d_pend), .h2d_busy(h2d_busy),
    .d2h_pend(d2h_pend), .d2h_busy(d2h_busy), .ctl_word(ctl_word)
);

// File: tb/sim_hdmbx_top.sv
`timescale 1ns/1ps
module sim_hdmbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  h_addr = '0, h_wdata = '0, h_rdata;
    logic        h_wr = 1'b0, h_rd = 1'b0, h_irq;
    logic [15:0] d_addr = '0;
    logic [7:0]  d_wdata = '0, d_rdata;
    logic        d_wr = 1'b0, d_rd = 1'b0, d_irq;

    int nvec = 0;
    int nbad = 0;
    bit done = 1'b0;

    // reference model, built from the requirements
    logic [7:0]  m_h2d_vec, m_d2h_vec;
    logic        m_h2d_pend, m_h2d_busy, m_h2d_en;
    logic        m_d2h_pend, m_d2h_busy, m_d2h_en;
    logic [15:0] m_ctl;

    always #10 clk = ~clk;

    hdmbx_top u0 (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq),
        .d_addr(d_addr), .d_wr(d_wr), .d_rd(d_rd), .d_wdata(d_wdata),
        .d_rdata(d_rdata), .d_irq(d_irq)
    );

    function automatic logic [7:0] exp_h(input logic [7:0] a);
        case (a)
            8'h50:   return {7'b0, m_h2d_busy};
            8'h58:   return m_d2h_vec;
            8'h75:   return {7'b0, m_d2h_pend};
            8'h76:   return {7'b0, m_d2h_en};
            8'h60:   return m_ctl[7:0];
            8'h61:   return m_ctl[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_d(input logic [15:0] a);
        case (a)
            16'h3058: return {7'b0, m_d2h_busy};
            16'h3050: return m_h2d_vec;
            16'h3074: return {7'b0, m_h2d_pend};
            16'h3076: return {7'b0, m_h2d_en};
            16'h3060: return m_ctl[7:0];
            16'h3061: return m_ctl[15:8];
            default:  return 8'h00;
        endcase
    endfunction

    function automatic string tag_h(input logic [7:0] a);
        case (a)
            8'h50: return "R2";  8'h58: return "R4";
            8'h75: return "R6";  8'h76: return "R6";
            8'h60: return "R7";  8'h61: return "R7";
            default: return "R11";
        endcase
    endfunction

    function automatic string tag_d(input logic [15:0] a);
        case (a)
            16'h3050: return "R2"; 16'h3058: return "R4";
            16'h3074: return "R6"; 16'h3076: return "R6";
            16'h3060: return "R7"; 16'h3061: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_h2d_vec = '0; m_d2h_vec = '0; m_ctl = '0;
        m_h2d_pend = 0; m_h2d_busy = 0; m_h2d_en = 0;
        m_d2h_pend = 0; m_d2h_busy = 0; m_d2h_en = 0;
    endtask

    // advance the model by one edge from the strobes being driven
    task automatic model_step();
        bit hs, hack, hclr, ds, dack, dclr;
        hs   = h_wr && h_addr == 8'h50;
        hack = h_rd && h_addr == 8'h58;
        hclr = h_wr && h_addr == 8'h58 && !h_wdata[0];
        ds   = d_wr && d_addr == 16'h3058;
        dack = d_rd && d_addr == 16'h3050;
        dclr = d_wr && d_addr == 16'h3050 && !d_wdata[0];
        if (hs) begin m_h2d_vec = h_wdata; m_h2d_pend = 1; m_h2d_busy = 1; end
        else begin
            if (dack) m_h2d_pend = 0;
            if (dclr) m_h2d_busy = 0;
        end
        if (ds) begin m_d2h_vec = d_wdata; m_d2h_pend = 1; m_d2h_busy = 1; end
        else begin
            if (hack) m_d2h_pend = 0;
            if (hclr) m_d2h_busy = 0;
        end
        if (h_wr && h_addr == 8'h76) m_d2h_en = h_wdata[0];
        if (d_wr && d_addr == 16'h3076) m_h2d_en = d_wdata[0];
        if (d_wr && d_addr == 16'h3060) m_ctl[7:0] = d_wdata;
        else if (h_wr && h_addr == 8'h60) m_ctl[7:0] = h_wdata;
        if (d_wr && d_addr == 16'h3061) m_ctl[15:8] = d_wdata;
        else if (h_wr && h_addr == 8'h61) m_ctl[15:8] = h_wdata;
    endtask

    // one bus cycle on both ports: op 0 idle, 1 read, 2 write
    task automatic cycle(input int hop, input logic [7:0] ha, input logic [7:0] hw,
                         input int dop, input logic [15:0] da, input logic [7:0] dw,
                         input string tag);
        @(negedge clk);
        h_addr = ha; h_wdata = hw; h_rd = (hop == 1); h_wr = (hop == 2);
        d_addr = da; d_wdata = dw; d_rd = (dop == 1); d_wr = (dop == 2);
        #1;
        if (h_rd) check(tag != "" ? tag : tag_h(ha), h_rdata, exp_h(ha));
        else      check("R11", h_rdata, 8'h00);
        if (d_rd) check(tag != "" ? tag : tag_d(da), d_rdata, exp_d(da));
        else      check("R11", d_rdata, 8'h00);
        check("R6", {7'b0, h_irq}, {7'b0, m_d2h_pend & m_d2h_en});
        check("R6", {7'b0, d_irq}, {7'b0, m_h2d_pend & m_h2d_en});
        @(posedge clk);
        model_step();
    endtask

    localparam logic [7:0]  HLIST [7] = '{8'h50, 8'h58, 8'h75, 8'h76, 8'h60, 8'h61, 8'h33};
    localparam logic [15:0] DLIST [7] = '{16'h3050, 16'h3058, 16'h3074, 16'h3076,
                                          16'h3060, 16'h3061, 16'h1234};

    initial begin
        model_reset();
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state seen through every mapped register
        for (int i = 0; i < 7; i++) cycle(1, HLIST[i], 8'h00, 1, DLIST[i], 8'h00, "R10");

        // R1/R2/R6: ring host-to-DSP while masked, then enable
        cycle(2, 8'h50, 8'hA5, 0, 16'h0, 8'h0, "R1");
        cycle(0, 8'h0, 8'h0, 1, 16'h3074, 8'h0, "R1");
        cycle(0, 8'h0, 8'h0, 1, 16'h3074, 8'h0, "R6");
        cycle(0, 8'h0, 8'h0, 2, 16'h3076, 8'h01, "R6");
        cycle(1, 8'h50, 8'h0, 1, 16'h3050, 8'h0, "R2");
        cycle(1, 8'h50, 8'h0, 1, 16'h3074, 8'h0, "R2");
        // R3: bit0=1 ignored, bit0=0 releases
        cycle(0, 8'h0, 8'h0, 2, 16'h3050, 8'hFF, "R3");
        cycle(1, 8'h50, 8'h0, 0, 16'h0, 8'h0, "R3");
        cycle(0, 8'h0, 8'h0, 2, 16'h3050, 8'hFE, "R3");
        cycle(1, 8'h50, 8'h0, 0, 16'h0, 8'h0, "R3");

        // R4/R5: DSP-to-host doorbell
        cycle(2, 8'h76, 8'h01, 2, 16'h3058, 8'h3C, "R4");
        cycle(1, 8'h58, 8'h0, 1, 16'h3058, 8'h0, "R4");
        cycle(1, 8'h75, 8'h0, 1, 16'h3058, 8'h0, "R4");
        cycle(2, 8'h58, 8'h01, 0, 16'h0, 8'h0, "R5");
        cycle(0, 8'h0, 8'h0, 1, 16'h3058, 8'h0, "R5");
        cycle(2, 8'h58, 8'h00, 0, 16'h0, 8'h0, "R5");
        cycle(0, 8'h0, 8'h0, 1, 16'h3058, 8'h0, "R5");

        // R9: set and clear collide in one cycle
        cycle(2, 8'h50, 8'h77, 1, 16'h3050, 8'h0, "R9");
        cycle(0, 8'h0, 8'h0, 1, 16'h3074, 8'h0, "R9");
        cycle(2, 8'h50, 8'h78, 2, 16'h3050, 8'h00, "R9");
        cycle(1, 8'h50, 8'h0, 0, 16'h0, 8'h0, "R9");
        cycle(1, 8'h58, 8'h0, 2, 16'h3058, 8'h11, "R9");
        cycle(1, 8'h75, 8'h0, 0, 16'h0, 8'h0, "R9");

        // R7/R8: parameter word, collision on the low byte
        cycle(2, 8'h61, 8'hBE, 2, 16'h3060, 8'hEF, "R7");
        cycle(1, 8'h60, 8'h0, 1, 16'h3061, 8'h0, "R7");
        cycle(2, 8'h60, 8'h12, 2, 16'h3060, 8'h34, "R8");
        cycle(1, 8'h60, 8'h0, 1, 16'h3060, 8'h0, "R8");

        // R11: unmapped writes then a full read-back
        cycle(2, 8'h33, 8'hFF, 2, 16'h1234, 8'hFF, "R11");
        for (int i = 0; i < 7; i++) cycle(1, HLIST[i], 8'h00, 1, DLIST[i], 8'h00, "R11");

        // random traffic on both ports
        for (int n = 0; n < 4000; n++) begin
            int hop, dop;
            hop = $urandom % 3; dop = $urandom % 3;
            cycle(hop, HLIST[$urandom % 7], 8'($urandom),
                  dop, DLIST[$urandom % 7], 8'($urandom), "");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule